// File: doc/BRIEF.md
# Interrupt Mask Set/Clear Controller

This block gates three interrupt sources through one enable bit per source: an asynchronous access timeout, a line trap and a wait-pin rising edge. Software reaches the enables through two register aliases. Writing 1 to a bit of the set alias turns a source on, and writing 1 to a bit of the clear alias turns it off. Either alias reads back the live enable state.

Each source delivers a one-cycle event pulse, which is captured in a raw status register. A masked status view shows only those captured events whose source is enabled. A single interrupt line is the registered OR of that masked view.

The register port is a plain address / write enable / write data / read data interface. Reads are combinational from the current state. Writes take effect on the clock edge that samples them.

Top module: `irq_mask_ctl`

## Requirements
- R1: After reset every enable bit, every raw status bit and `irq_o` are 0, so all sources start disabled.
- R2: A write to offset 0x8 (set alias) sets each enable bit whose write-data bit is 1: bit 0 is the access timeout source, bit 1 the line trap source and bit 2 the wait rising-edge source. Data bits that are 0 leave their enable unchanged.
- R3: A write to offset 0xC (clear alias) clears each enable bit whose write-data bit is 1, with the same bit positions. Data bits that are 0 leave their enable unchanged. Once cleared, an enable returns only through the set alias.
- R4: Reads of offset 0x8 and offset 0xC both return the enable bits in bits 2:0 and 0 in bits 31:3. Write-data bits 31:3 have no effect on any enable.
- R5: Offset 0x0 (raw status) captures an event pulse on `src_event[i]` into bit i, whether or not source i is enabled. Writing 1 to a bit clears it. If an event arrives on the same edge as a clearing write to the same bit, the event wins and the bit is left set.
- R6: Offset 0x4 (masked status) reads raw status AND enables in bits 2:0, so a disabled source always reads 0 there. Writes to offset 0x4 change nothing.
- R7: `irq_o` is 1 exactly one clock after any bit of the masked status is 1, and 0 one clock after all of its bits are 0.
- R8: Any offset other than 0x0, 0x4, 0x8 or 0xC reads as 0. A write to such an offset changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 4 | Register byte offset |
| reg_wr_en | input | 1 | Write strobe for the current offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current offset (combinational) |
| src_event | input | 3 | One-cycle event pulses: bit 0 timeout, bit 1 line trap, bit 2 wait rise |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions assume that `reg_wr_en` is low throughout reset. They also assume that every input is stable across each rising edge, so each `$past` sample of a write or event pulse is the one the registers captured. The bench holds the write strobe and the event pulses low while reset is active. It changes every input only on falling edges, and it raises each event for exactly one cycle, as the event sources are expected to. The R5 collision case deliberately drives an event and a clearing write in the same cycle, because the requirement defines that case.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int unsigned SRC_COUNT  = 3;
    localparam int unsigned REG_DATA_W = 32;
    localparam int unsigned REG_ADDR_W = 4;

    // Byte offsets of the four registers
    localparam int unsigned OFS_RAW = 'h0;
    localparam int unsigned OFS_MSK = 'h4;
    localparam int unsigned OFS_SET = 'h8;
    localparam int unsigned OFS_CLR = 'hC;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_RAW  = 3'd1,
        SEL_MSK  = 3'd2,
        SEL_SET  = 3'd3,
        SEL_CLR  = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W = REG_ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    output reg_sel_e          sel,
    output logic              wr_raw,
    output logic              wr_set,
    output logic              wr_clr
);

    localparam logic [ADDR_W-1:0] A_RAW = ADDR_W'(OFS_RAW);
    localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(OFS_MSK);
    localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(OFS_SET);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFS_CLR);

    always_comb begin
        unique case (addr)
            A_RAW:   sel = SEL_RAW;
            A_MSK:   sel = SEL_MSK;
            A_SET:   sel = SEL_SET;
            A_CLR:   sel = SEL_CLR;
            default: sel = SEL_NONE;
        endcase
    end

    // The masked view is read-only; unmapped offsets take no write.
    always_comb begin
        wr_raw = wr_en && (sel == SEL_RAW);
        wr_set = wr_en && (sel == SEL_SET);
        wr_clr = wr_en && (sel == SEL_CLR);
    end

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
    parameter int unsigned N_SRC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_set,
    input  logic             wr_clr,
    input  logic [N_SRC-1:0] wbits,
    output logic [N_SRC-1:0] mask_q
);

    typedef struct packed {
        logic [N_SRC-1:0] en;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_set) begin
            st_d.en = st_q.en | wbits;
        end else if (wr_clr) begin
            st_d.en = st_q.en & ~wbits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_q = st_q.en;

endmodule

// File: rtl/irq_event_latch.sv
module irq_event_latch #(
    parameter int unsigned N_SRC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_event,
    input  logic             wr_ack,
    input  logic [N_SRC-1:0] wbits,
    output logic [N_SRC-1:0] raw_q
);

    typedef struct packed {
        logic [N_SRC-1:0] pend;
    } latch_t;

    latch_t st_d, st_q;

    // One cell per source: a new event takes priority over a clearing write.
    for (genvar i = 0; i < N_SRC; i++) begin : g_cell
        always_comb begin
            if (src_event[i]) begin
                st_d.pend[i] = 1'b1;
            end else if (wr_ack && wbits[i]) begin
                st_d.pend[i] = 1'b0;
            end else begin
                st_d.pend[i] = st_q.pend[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_q = st_q.pend;

endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen #(
    parameter int unsigned N_SRC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] raw,
    input  logic [N_SRC-1:0] mask,
    output logic [N_SRC-1:0] masked,
    output logic             irq_o
);

    typedef struct packed {
        logic req;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        masked   = raw & mask;
        st_d     = st_q;
        st_d.req = |masked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.req;

endmodule

// File: rtl/irq_mask_ctl.sv
module irq_mask_ctl
    import irq_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W = REG_ADDR_W,
    parameter int unsigned DATA_W = REG_DATA_W,
    parameter int unsigned N_SRC  = SRC_COUNT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_SRC-1:0]  src_event,
    output logic              irq_o
);

    localparam int unsigned PAD_W = DATA_W - N_SRC;

    reg_sel_e         sel;
    logic             wr_raw, wr_set, wr_clr;
    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] raw_q;
    logic [N_SRC-1:0] masked;
    logic [N_SRC-1:0] wbits;
    logic             unused_wdata_hi;

    assign wbits           = reg_wdata[N_SRC-1:0];
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:N_SRC];

    irq_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (reg_addr),
        .wr_en  (reg_wr_en),
        .sel    (sel),
        .wr_raw (wr_raw),
        .wr_set (wr_set),
        .wr_clr (wr_clr)
    );

    irq_mask_bank #(.N_SRC(N_SRC)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_set (wr_set),
        .wr_clr (wr_clr),
        .wbits  (wbits),
        .mask_q (mask_q)
    );

    irq_event_latch #(.N_SRC(N_SRC)) u_raw (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_event (src_event),
        .wr_ack    (wr_raw),
        .wbits     (wbits),
        .raw_q     (raw_q)
    );

    irq_out_gen #(.N_SRC(N_SRC)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (raw_q),
        .mask   (mask_q),
        .masked (masked),
        .irq_o  (irq_o)
    );

    always_comb begin
        unique case (sel)
            SEL_RAW:          reg_rdata = {{PAD_W{1'b0}}, raw_q};
            SEL_MSK:          reg_rdata = {{PAD_W{1'b0}}, masked};
            SEL_SET, SEL_CLR: reg_rdata = {{PAD_W{1'b0}}, mask_q};
            default:          reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_mask_ctl_chk.sv
module irq_mask_ctl_chk #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned N_SRC  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr_en,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [N_SRC-1:0]  src_event,
    input logic              irq_o,
    input logic [N_SRC-1:0]  mask_q,
    input logic [N_SRC-1:0]  raw_q
);

    localparam logic [ADDR_W-1:0] A_RAW = ADDR_W'('h0);
    localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'('h4);
    localparam logic [ADDR_W-1:0] A_SET = ADDR_W'('h8);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'('hC);

    logic             mapped;
    logic             alias_sel;
    logic [N_SRC-1:0] wlo;
    logic             unused_chk_hi;

    assign mapped        = (reg_addr == A_RAW) || (reg_addr == A_MSK) ||
                           (reg_addr == A_SET) || (reg_addr == A_CLR);
    assign alias_sel     = (reg_addr == A_SET) || (reg_addr == A_CLR);
    assign wlo           = reg_wdata[N_SRC-1:0];
    assign unused_chk_hi = ^reg_wdata[DATA_W-1:N_SRC];

    assert_set_alias_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == A_SET) |=> ((mask_q & $past(wlo)) == $past(wlo)));

    assert_clr_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == A_CLR) |=> ((mask_q & $past(wlo)) == '0));

    assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && alias_sel) |=> $stable(mask_q));

    assert_alias_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        alias_sel |-> (reg_rdata == DATA_W'(mask_q)));

    assert_event_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_event != '0) |=> ((raw_q & $past(src_event)) == $past(src_event)));

    assert_masked_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_MSK && mask_q == '0) |-> (reg_rdata == '0));

    assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_q & mask_q) != '0) |=> irq_o);

    assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_q & mask_q) == '0) |=> !irq_o);

    assert_unmapped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (reg_rdata == '0));

endmodule

bind irq_mask_ctl irq_mask_ctl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .N_SRC  (N_SRC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr_en (reg_wr_en),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .src_event (src_event),
    .irq_o     (irq_o),
    .mask_q    (mask_q),
    .raw_q     (raw_q)
);

// File: tb/irq_mask_ctl_tb.sv
module irq_mask_ctl_tb;

    localparam int unsigned AW = 4;
    localparam int unsigned DW = 32;
    localparam int unsigned NS = 3;

    // step kinds: 0 write, 1 event pulse, 2 read and compare
    typedef struct packed {
        logic [1:0]    kind;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [DW-1:0] expv;
        logic [7:0]    req;
    } step_t;

    localparam int NSTEP = 31;
    localparam step_t STEPS [NSTEP] = '{
        '{2'd2, 4'h8, 32'h0,        32'h0, 8'd1},  // R1 set alias
        '{2'd2, 4'hC, 32'h0,        32'h0, 8'd1},  // R1 clear alias
        '{2'd2, 4'h0, 32'h0,        32'h0, 8'd1},  // R1 raw
        '{2'd0, 4'h8, 32'h5,        32'h0, 8'd2},
        '{2'd2, 4'h8, 32'h0,        32'h5, 8'd2},  // R2
        '{2'd2, 4'hC, 32'h0,        32'h5, 8'd4},  // R4 both aliases agree
        '{2'd0, 4'h8, 32'h0,        32'h0, 8'd2},
        '{2'd2, 4'hC, 32'h0,        32'h5, 8'd2},  // R2 zeros ignored
        '{2'd0, 4'hC, 32'h1,        32'h0, 8'd3},
        '{2'd2, 4'h8, 32'h0,        32'h4, 8'd3},  // R3
        '{2'd2, 4'hC, 32'h0,        32'h4, 8'd3},
        '{2'd0, 4'hC, 32'h0,        32'h0, 8'd3},
        '{2'd2, 4'h8, 32'h0,        32'h4, 8'd3},  // R3 zeros ignored
        '{2'd0, 4'h8, 32'hFFFFFFF8, 32'h0, 8'd4},
        '{2'd2, 4'h8, 32'h0,        32'h4, 8'd4},  // R4 upper bits ignored
        '{2'd1, 4'h0, 32'h3,        32'h0, 8'd5},
        '{2'd2, 4'h0, 32'h0,        32'h3, 8'd5},  // R5 captured while disabled
        '{2'd2, 4'h4, 32'h0,        32'h0, 8'd6},  // R6 disabled reads 0
        '{2'd1, 4'h0, 32'h4,        32'h0, 8'd5},
        '{2'd2, 4'h0, 32'h0,        32'h7, 8'd5},
        '{2'd2, 4'h4, 32'h0,        32'h4, 8'd6},
        '{2'd0, 4'h4, 32'h7,        32'h0, 8'd6},
        '{2'd2, 4'h0, 32'h0,        32'h7, 8'd6},  // R6 write ignored
        '{2'd0, 4'h0, 32'h2,        32'h0, 8'd5},
        '{2'd2, 4'h0, 32'h0,        32'h5, 8'd5},  // R5 write-one-to-clear
        '{2'd0, 4'h8, 32'h3,        32'h0, 8'd2},
        '{2'd2, 4'h4, 32'h0,        32'h5, 8'd6},
        '{2'd2, 4'h2, 32'h0,        32'h0, 8'd8},  // R8 unmapped read
        '{2'd0, 4'h1, 32'h7,        32'h0, 8'd8},
        '{2'd2, 4'h0, 32'h0,        32'h5, 8'd8},  // R8 write ignored
        '{2'd2, 4'h8, 32'h0,        32'h7, 8'd8}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_wr_en = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [NS-1:0] src_event = '0;
    logic          irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    irq_mask_ctl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr_en (reg_wr_en),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .src_event (src_event),
        .irq_o     (irq_o)
    );

    task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] expv);
        n_checks++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, expv);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic [NS-1:0] e);
        @(negedge clk);
        src_event = e;
        @(negedge clk);
        src_event = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] expv, input string tag);
        @(negedge clk);
        reg_addr = a;
        #2;
        check(tag, reg_rdata, expv);
    endtask

    task automatic irq_chk(input logic expv, input string tag);
        #2;
        check(tag, {31'b0, irq_o}, {31'b0, expv});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        irq_chk(1'b0, "R1 irq in reset");
        rst_n = 1'b1;
        @(negedge clk);
        irq_chk(1'b0, "R1 irq after reset");

        foreach (STEPS[i]) begin
            step_t s = STEPS[i];
            case (s.kind)
                2'd0: wr(s.addr, s.data);
                2'd1: pulse(s.data[NS-1:0]);
                default: rd(s.addr, s.expv, $sformatf("R%0d step %0d", s.req, i));
            endcase
        end

        // R7: interrupt latency and gating
        wr(4'h0, 32'h7);
        wr(4'hC, 32'h7);
        wr(4'h8, 32'h2);
        irq_chk(1'b0, "R7 idle");
        pulse(3'b010);
        irq_chk(1'b0, "R7 not before one cycle");
        @(negedge clk);
        irq_chk(1'b1, "R7 raised");
        wr(4'hC, 32'h2);
        irq_chk(1'b1, "R7 still high one cycle");
        @(negedge clk);
        irq_chk(1'b0, "R7 dropped after disable");
        rd(4'h0, 32'h2, "R5 raw kept while disabled");
        pulse(3'b001);
        @(negedge clk);
        irq_chk(1'b0, "R6 disabled source gives no irq");

        // R5: event beats clearing write on the same edge
        @(negedge clk);
        reg_addr = 4'h0; reg_wdata = 32'h3; reg_wr_en = 1'b1; src_event = 3'b001;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0; src_event = '0;
        rd(4'h0, 32'h1, "R5 event wins collision");

        // R3: re-enable only via set alias
        wr(4'hC, 32'h1);
        rd(4'h8, 32'h0, "R3 cleared");
        wr(4'h8, 32'h1);
        rd(4'hC, 32'h1, "R3 re-enabled via set");

        // R1: reset in mid-run
        @(negedge clk);
        irq_chk(1'b1, "R7 high before reset");
        rst_n = 1'b0;
        reg_addr = 4'h8;
        #2;
        check("R1 mask cleared by reset", reg_rdata, 32'h0);
        reg_addr = 4'h0;
        #1;
        check("R1 raw cleared by reset", reg_rdata, 32'h0);
        irq_chk(1'b0, "R1 irq cleared by reset");
        @(negedge clk);
        rst_n = 1'b1;
        rd(4'hC, 32'h0, "R1 clear alias after reset");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule